// File: doc/BRIEF.md
# NAND ECC Syndrome Classifier

This block decides what to do with one 512-byte chunk of a NAND page after the controller has recomputed its 3-byte Hamming code. It takes the code that was stored in the spare area and the code recomputed from the data. Their bytewise difference (the syndrome) is sorted into one of four outcomes: the data is clean, one data bit must be flipped, only the code bytes were damaged, or the chunk cannot be repaired. For a repairable chunk it also gives the byte offset inside the chunk and the bit inside that byte.

Software or a DMA engine presents both triplets with a one-cycle strobe. One cycle later the block returns a registered verdict with a done pulse, and the verdict holds until the next strobe. A configuration input lets a chunk whose stored code is still erased (all ones) count as never protected instead of as damaged. The block neither computes the code nor flips the bit in the buffer.

Top module: `nand_ecc_fixer`

## Requirements
- R1: Byte k of each triplet sits on bits 8k+7:8k. When the stored and fresh triplets are equal, the status is 0 (clean).
- R2: When the syndrome is nonzero, the stored triplet is FF FF FF and `ignore_blank` is 1, the status is 0. This takes priority over R3, R6 and R7. With `ignore_blank` at 0, an erased stored triplet is classified like any other.
- R3: When each syndrome byte d satisfies ((d ^ (d >> 1)) & 0x55) == 0x55, the status is 1 (data bit to be corrected). Each of the 12 adjacent bit pairs then differs.
- R4: With status 1, `byte_idx` bit 8 is syndrome byte 2 bit 1. Bits 7..4 are syndrome byte 1 bits 7, 5, 3, 1. Bits 3..0 are syndrome byte 0 bits 7, 5, 3, 1.
- R5: With status 1, `bit_idx` bits 0, 1, 2 are syndrome byte 2 bits 3, 5, 7.
- R6: A nonzero syndrome not covered by R2 or R3 that has exactly one of its 24 bits set gives status 2 (error in the code bytes only).
- R7: Any other nonzero syndrome gives status 3 (uncorrectable).
- R8: Whenever the status is not 1, `byte_idx` and `bit_idx` are zero.
- R9: `done` is high in exactly the cycle after a cycle with `chk_valid` high, and low otherwise. The outputs show the verdict for those inputs in that same cycle.
- R10: In a cycle with `chk_valid` low, the inputs have no effect. Status and indices keep their last values.
- R11: After a synchronous reset, `done`, `status`, `byte_idx` and `bit_idx` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chk_valid | input | 1 | One-cycle strobe: triplets are valid |
| ignore_blank | input | 1 | Treat an all-ones stored triplet as unprotected |
| stored_ecc | input | 24 | Code read from the spare area, byte 0 in bits 7:0 |
| fresh_ecc | input | 24 | Code recomputed from the data, byte 0 in bits 7:0 |
| done | output | 1 | Verdict is ready |
| status | output | 2 | 0 clean, 1 data bit corrected, 2 code-only error, 3 uncorrectable |
| byte_idx | output | 9 | Byte offset of the bad bit (status 1 only) |
| bit_idx | output | 3 | Bit number in that byte (status 1 only) |

## Verification
The erased-code exemption and the repair decode can both apply to the same strobe. This happens when the stored triplet is all ones and the syndrome also forms a correctable pattern, a single-bit pattern or a random pattern. The bench sends each such case twice, with `ignore_blank` high and then low. It expects the exemption to win with zero indices in the first case, and the normal classification with a decoded location in the second. Equal triplets of all ones are also sent, so that the clean check and the exemption agree.

// File: rtl/ecc_fix_pkg.sv
// Package: shared widths and result types for the ECC syndrome classifier.
// Assumes a three-byte Hamming code that protects a 512-byte chunk.
package ecc_fix_pkg;

    localparam int LANE_W     = 8;
    localparam int LANES      = 3;
    localparam int BYTE_IDX_W = 9;
    localparam int BIT_IDX_W  = 3;

    typedef enum logic [1:0] {
        FIX_CLEAN    = 2'd0,
        FIX_DATA     = 2'd1,
        FIX_ECC_ONLY = 2'd2,
        FIX_FATAL    = 2'd3
    } fix_status_e;

    typedef struct packed {
        fix_status_e           status;
        logic [BYTE_IDX_W-1:0] byte_idx;
        logic [BIT_IDX_W-1:0]  bit_idx;
    } fix_result_t;

endpackage

// File: rtl/ecc_syn_xor.sv
// Module: forms the syndrome lane by lane and flags a zero syndrome and an
// erased (all ones) stored code. Purely combinational.
module ecc_syn_xor #(
    parameter int LANE_W = 8,
    parameter int LANES  = 3,
    localparam int SYN_W = LANE_W * LANES
) (
    input  logic [SYN_W-1:0] stored,
    input  logic [SYN_W-1:0] fresh,
    output logic [SYN_W-1:0] syn,
    output logic             syn_zero,
    output logic             stored_blank
);

    logic [LANES-1:0] lane_zero;
    logic [LANES-1:0] lane_ones;

    // One lane per code byte: difference, zero test, erased test
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign syn[g*LANE_W +: LANE_W] = stored[g*LANE_W +: LANE_W] ^ fresh[g*LANE_W +: LANE_W];
        assign lane_zero[g]            = ~|syn[g*LANE_W +: LANE_W];
        assign lane_ones[g]            = &stored[g*LANE_W +: LANE_W];
    end

    // Combine the per-lane flags
    assign syn_zero     = &lane_zero;
    assign stored_blank = &lane_ones;

endmodule

// File: rtl/ecc_pair_screen.sv
// Module: checks whether every complementary parity pair of the syndrome
// differs (single data-bit signature). Also checks whether exactly one
// syndrome bit is set (code-byte damage). Combinational; the syndrome is
// taken as already formed.
module ecc_pair_screen #(
    parameter int LANE_W = 8,
    parameter int LANES  = 3,
    localparam int SYN_W = LANE_W * LANES
) (
    input  logic [SYN_W-1:0] syn,
    output logic             pairs_ok,
    output logic             one_hot
);

    function automatic logic [LANE_W-1:0] even_mask();
        logic [LANE_W-1:0] m;
        for (int i = 0; i < LANE_W; i++) m[i] = (i % 2 == 0);
        return m;
    endfunction

    localparam logic [LANE_W-1:0] EVEN_M = even_mask();
    localparam logic [SYN_W-1:0]  ONE    = {{(SYN_W-1){1'b0}}, 1'b1};

    logic [LANES-1:0] lane_ok;

    // Per lane: each bit pair must hold opposite values
    for (genvar g = 0; g < LANES; g++) begin : g_pair
        logic [LANE_W-1:0] d;
        assign d          = syn[g*LANE_W +: LANE_W];
        assign lane_ok[g] = ((d ^ (d >> 1)) & EVEN_M) == EVEN_M;
    end

    // Signature holds only if every lane matches
    assign pairs_ok = &lane_ok;

    // Exactly one set bit: nonzero and a power of two
    assign one_hot = (syn != '0) && ((syn & (syn - ONE)) == '0);

endmodule

// File: rtl/ecc_locate.sv
// Module: turns the odd-position syndrome bits into a byte offset and a
// bit number. Odd bit k of the syndrome is given as odd_bits[k]. Only
// meaningful when the pair screen accepts the syndrome.
module ecc_locate #(
    parameter int BYTE_IDX_W = 9,
    parameter int BIT_IDX_W  = 3,
    localparam int ODD_W     = BYTE_IDX_W + BIT_IDX_W
) (
    input  logic [ODD_W-1:0]      odd_bits,
    output logic [BYTE_IDX_W-1:0] byte_idx,
    output logic [BIT_IDX_W-1:0]  bit_idx
);

    // Low odd bits give the byte offset, the top ones the bit number
    assign byte_idx = odd_bits[BYTE_IDX_W-1:0];
    assign bit_idx  = odd_bits[ODD_W-1:BYTE_IDX_W];

endmodule

// File: rtl/nand_ecc_fixer.sv
// Module: top of the ECC syndrome classifier. Forms the syndrome,
// classifies it in a fixed priority (zero, erased-code exemption, data-bit
// signature, single code bit, otherwise fatal) and registers the verdict.
// The verdict appears with a one-cycle done pulse after chk_valid and is
// held until the next strobe. Assumes 3 lanes of 8 bits.
module nand_ecc_fixer
    import ecc_fix_pkg::*;
#(
    parameter int LANE_W   = ecc_fix_pkg::LANE_W,
    parameter int LANES    = ecc_fix_pkg::LANES,
    parameter int BYTE_I_W = ecc_fix_pkg::BYTE_IDX_W,
    parameter int BIT_I_W  = ecc_fix_pkg::BIT_IDX_W,
    localparam int SYN_W   = LANE_W * LANES,
    localparam int ODD_W   = SYN_W / 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                chk_valid,
    input  logic                ignore_blank,
    input  logic [SYN_W-1:0]    stored_ecc,
    input  logic [SYN_W-1:0]    fresh_ecc,
    output logic                done,
    output logic [1:0]          status,
    output logic [BYTE_I_W-1:0] byte_idx,
    output logic [BIT_I_W-1:0]  bit_idx
);

    logic [SYN_W-1:0]    syn;
    logic                syn_zero;
    logic                stored_blank;
    logic                pairs_ok;
    logic                one_hot;
    logic [ODD_W-1:0]    odd_bits;
    logic [BYTE_I_W-1:0] loc_byte;
    logic [BIT_I_W-1:0]  loc_bit;
    fix_result_t         nxt;
    fix_result_t         res_q;
    logic                done_q;

    ecc_syn_xor #(.LANE_W(LANE_W), .LANES(LANES)) u_xor (
        .stored       (stored_ecc),
        .fresh        (fresh_ecc),
        .syn          (syn),
        .syn_zero     (syn_zero),
        .stored_blank (stored_blank)
    );

    ecc_pair_screen #(.LANE_W(LANE_W), .LANES(LANES)) u_screen (
        .syn      (syn),
        .pairs_ok (pairs_ok),
        .one_hot  (one_hot)
    );

    // Pick out the odd syndrome bits that carry the location
    for (genvar k = 0; k < ODD_W; k++) begin : g_odd
        assign odd_bits[k] = syn[2*k+1];
    end

    ecc_locate #(.BYTE_IDX_W(BYTE_I_W), .BIT_IDX_W(BIT_I_W)) u_loc (
        .odd_bits (odd_bits),
        .byte_idx (loc_byte),
        .bit_idx  (loc_bit)
    );

    // Priority classification of the current syndrome
    always_comb begin
        nxt = '0;
        if (syn_zero) begin
            nxt.status = FIX_CLEAN;
        end else if (ignore_blank && stored_blank) begin
            nxt.status = FIX_CLEAN;
        end else if (pairs_ok) begin
            nxt.status   = FIX_DATA;
            nxt.byte_idx = loc_byte;
            nxt.bit_idx  = loc_bit;
        end else if (one_hot) begin
            nxt.status = FIX_ECC_ONLY;
        end else begin
            nxt.status = FIX_FATAL;
        end
    end

    // Register the verdict on a strobe and pulse done one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            res_q  <= '0;
        end else begin
            done_q <= chk_valid;
            if (chk_valid) res_q <= nxt;
        end
    end

    assign done     = done_q;
    assign status   = res_q.status;
    assign byte_idx = res_q.byte_idx;
    assign bit_idx  = res_q.bit_idx;

endmodule

// File: rtl/nand_ecc_fixer_chk.sv
// Checker: port-level temporal properties of the ECC syndrome classifier.
// Attached to every instance of the top by the bind below.
module nand_ecc_fixer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        chk_valid,
    input logic        ignore_blank,
    input logic [23:0] stored_ecc,
    input logic [23:0] fresh_ecc,
    input logic        done,
    input logic [1:0]  status,
    input logic [8:0]  byte_idx,
    input logic [2:0]  bit_idx
);

    // R1
    clean_on_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid && (stored_ecc == fresh_ecc) |=> status == 2'd0);

    // R2
    blank_exempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid && ignore_blank && (stored_ecc == 24'hFFFFFF) |=> status == 2'd0);

    // R6
    single_code_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid && !(ignore_blank && (stored_ecc == 24'hFFFFFF))
        && ($countones(stored_ecc ^ fresh_ecc) == 1) |=> status == 2'd2);

    // R8
    idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 2'd1) |-> (byte_idx == 9'd0) && (bit_idx == 3'd0));

    // R9
    done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> done);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !done);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> $stable(status) && $stable(byte_idx) && $stable(bit_idx));

endmodule

bind nand_ecc_fixer nand_ecc_fixer_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .chk_valid    (chk_valid),
    .ignore_blank (ignore_blank),
    .stored_ecc   (stored_ecc),
    .fresh_ecc    (fresh_ecc),
    .done         (done),
    .status       (status),
    .byte_idx     (byte_idx),
    .bit_idx      (bit_idx)
);

// File: tb/nand_ecc_fixer_tb_top.sv
// Bench: behavioural reference model updated on every rising edge and
// compared with the design on every falling edge.
module nand_ecc_fixer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        chk_valid;
    logic        ignore_blank;
    logic [23:0] stored_ecc;
    logic [23:0] fresh_ecc;
    logic        done;
    logic [1:0]  status;
    logic [8:0]  byte_idx;
    logic [2:0]  bit_idx;

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 0;
    bit finished = 0;

    // Model state
    bit          m_done;
    int          m_status;
    int          m_byte;
    int          m_bit;
    int          m_why;  // 0 reset, 1 zero, 2 blank, 3 other verdict, 4 hold

    always #4 clk = ~clk;

    nand_ecc_fixer dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .chk_valid    (chk_valid),
        .ignore_blank (ignore_blank),
        .stored_ecc   (stored_ecc),
        .fresh_ecc    (fresh_ecc),
        .done         (done),
        .status       (status),
        .byte_idx     (byte_idx),
        .bit_idx      (bit_idx)
    );

    // Reference classification written from the requirements
    function automatic int ref_status(input logic [23:0] s, input logic [23:0] f, input bit ign);
        logic [23:0] d = s ^ f;
        int ones = 0;
        bit pairs = 1;
        for (int i = 0; i < 24; i++) ones += d[i];
        for (int p = 0; p < 12; p++) if (d[2*p] == d[2*p+1]) pairs = 0;
        if (ones == 0) return 0;
        if (ign && s == 24'hFFFFFF) return 0;
        if (pairs) return 1;
        if (ones == 1) return 2;
        return 3;
    endfunction

    function automatic int ref_byte(input logic [23:0] d);
        int b = 0;
        for (int k = 0; k < 4; k++) b += d[2*k+1] << k;        // byte 0 bits 1,3,5,7
        for (int k = 0; k < 4; k++) b += d[8+2*k+1] << (4+k);  // byte 1 bits 1,3,5,7
        b += d[17] << 8;                                       // byte 2 bit 1
        return b;
    endfunction

    function automatic int ref_bit(input logic [23:0] d);
        return d[19] + 2*d[21] + 4*d[23];
    endfunction

    // Build a syndrome that flags data byte b, bit t
    function automatic logic [23:0] make_diff(input int b, input int t);
        logic [23:0] d;
        for (int k = 0; k < 12; k++) begin
            bit v = (k < 9) ? b[k] : t[k-9];
            d[2*k+1] = v;
            d[2*k]   = ~v;
        end
        return d;
    endfunction

    // Model update on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_done <= 0; m_status <= 0; m_byte <= 0; m_bit <= 0; m_why <= 0;
        end else begin
            m_done <= chk_valid;
            if (chk_valid) begin
                int st;
                st = ref_status(stored_ecc, fresh_ecc, ignore_blank);
                m_status <= st;
                m_byte   <= (st == 1) ? ref_byte(stored_ecc ^ fresh_ecc) : 0;
                m_bit    <= (st == 1) ? ref_bit(stored_ecc ^ fresh_ecc) : 0;
                m_why    <= (stored_ecc == fresh_ecc) ? 1
                          : (ignore_blank && stored_ecc == 24'hFFFFFF) ? 2 : 3;
            end else begin
                m_why <= 4;
            end
        end
    end

    function automatic string why_tag(input int why, input int st);
        case (why)
            0: return "R11";
            1: return "R1";
            2: return "R2";
            4: return "R10";
            default: case (st)
                1: return "R3 R4 R5";
                2: return "R6 R8";
                default: return "R7 R8";
            endcase
        endcase
    endfunction

    // Compare on every falling edge
    always @(negedge clk) begin
        if (started && !finished) begin
            n_cmp++;
            if (done !== m_done) begin
                n_bad++;
                $display("FAIL R9: done actual %0b expected %0b", done, m_done);
            end
            if (status !== m_status[1:0] || byte_idx !== m_byte[8:0] || bit_idx !== m_bit[2:0]) begin
                n_bad++;
                $display("FAIL %s: status/byte/bit actual %0d/%0d/%0d expected %0d/%0d/%0d",
                         why_tag(m_why, m_status), status, byte_idx, bit_idx,
                         m_status, m_byte, m_bit);
            end
        end
    end

    task automatic apply(input logic [23:0] s, input logic [23:0] f, input bit ign);
        @(negedge clk);
        chk_valid = 1; stored_ecc = s; fresh_ecc = f; ignore_blank = ign;
    endtask

    // R10: idle cycles with junk on the data inputs
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk_valid = 0; stored_ecc = $urandom; fresh_ecc = $urandom; ignore_blank = $urandom;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL R9: watchdog actual hung expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] s;
        rst_n = 0; chk_valid = 0; ignore_blank = 0; stored_ecc = '0; fresh_ecc = '0;
        @(negedge clk); started = 1;   // R11 reset state compared from here
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle(2);

        // R1: equal triplets, including all ones
        for (int i = 0; i < 5; i++) begin s = $urandom; apply(s, s, $urandom); end
        apply(24'hFFFFFF, 24'hFFFFFF, 1);
        apply(24'hFFFFFF, 24'hFFFFFF, 0);
        idle(2);

        // R3 R4 R5: correctable, including byte offsets 0 and 511
        for (int t = 0; t < 24; t++) begin
            int b = (t == 0) ? 0 : (t == 1) ? 511 : int'($urandom_range(511));
            s = $urandom;
            apply(s, s ^ make_diff(b, t % 8), 0);
        end
        idle(3);

        // R2: erased code with each kind of syndrome, exemption on and off
        apply(24'hFFFFFF, 24'hFFFFFF ^ make_diff(300, 5), 1);
        apply(24'hFFFFFF, 24'hFFFFFF ^ make_diff(300, 5), 0);
        apply(24'hFFFFFF, 24'hFFFFFF ^ 24'h000400, 1);
        apply(24'hFFFFFF, 24'hFFFFFF ^ 24'h000400, 0);
        apply(24'hFFFFFF, 24'h123456, 1);
        apply(24'hFFFFFF, 24'h123456, 0);
        apply(24'hFFFFFE, 24'h123456, 1);
        idle(2);

        // R6: each single syndrome bit
        for (int p = 0; p < 24; p++) begin s = $urandom; apply(s, s ^ (24'h1 << p), $urandom); end
        idle(2);

        // R7: same-pair damage, signature plus one bit, random
        apply(24'h0, 24'h000003, 0);
        apply(24'h0, make_diff(77, 2) ^ 24'h000003, 0);
        for (int i = 0; i < 30; i++) apply($urandom, $urandom, 0);
        idle(3);

        // Mixed traffic with gaps
        for (int i = 0; i < 40; i++) begin
            if ($urandom_range(3) == 0) idle(1);
            case ($urandom_range(2))
                0: begin s = $urandom; apply(s, s ^ make_diff($urandom_range(511), $urandom_range(7)), $urandom); end
                1: begin s = $urandom; apply(s, s ^ (24'h1 << $urandom_range(23)), 0); end
                default: apply($urandom, $urandom, $urandom);
            endcase
        end
        idle(4);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule